// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. It stores 256 words of a configurable width (9 bits by default, 18 bits as the other intended setting). Its read timing follows one of two modes. The mode is captured from a select input while reset is held, and it stays fixed until the next reset.

In standard mode a stored word reaches the data output only when the reader asks for it. An active-low empty indication and an active-low full indication are provided. In fall-through mode the oldest word moves onto the output by itself and waits there for the reader. Because the output register then holds one word, the capacity grows to 257 words. The status outputs change meaning in this mode: an active-low output-ready and an input-ready that is high when writes are refused.

Pointers cross between the clock domains as Gray codes through two-stage synchronizers. As a result the flags are sometimes late, but they are never wrong in the unsafe direction.

Top module: `dual_mode_fifo`

## Requirements
- R1: The read timing mode is loaded from `fwftSel` (0 = standard, 1 = fall-through) only on clock edges while `rstN` is low. Changes to `fwftSel` after reset have no effect on flag polarity or output behaviour.
- R2: In standard mode, a written word does not appear on `rdData`, and `rdData` holds its previous value, until a rising `rdClk` edge with `rdEn` high performs a read. After that edge `rdData` shows the oldest stored word.
- R3: In standard mode, `rdFlag` is the active-low empty indication. It rises to 1 after the second rising `rdClk` edge that follows the write edge into an empty buffer. It falls to 0 right after the read of the last word. A read while `rdFlag` is 0 leaves `rdData` and the stored contents unchanged.
- R4: In standard mode, `wrFlag` is the active-low full indication. It is 0 after 256 writes with no reads. A write while it is 0 is discarded. It returns to 1 once a read has been seen by the write side.
- R5: Words leave in the order they were written, in both modes.
- R6: In fall-through mode, the first word written into an empty buffer is on `rdData`, with `rdFlag` at 0, after the third rising `rdClk` edge following the write edge, without `rdEn`.
- R7: In fall-through mode, `rdFlag` is active-low output-ready. While it is 0 with `rdEn` low, `rdData` is held. A rising `rdClk` edge with `rdEn` high consumes the word. After the last word is consumed `rdFlag` is 1, and `rdEn` then leaves `rdData` unchanged.
- R8: In fall-through mode, `wrFlag` is input-ready, where 1 means not ready. It stays 0 after 256 writes and becomes 1 after 257 writes with no reads. A write while it is 1 is discarded. It returns to 0 after a read.
- R9: Right after reset `rdData` is 0. In standard mode `rdFlag`=0 and `wrFlag`=1. In fall-through mode `rdFlag`=1 and `wrFlag`=0.
- R10: Each pointer crossing a clock domain changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEn | input | 1 | Write request, active high |
| wrData | input | DATA_W | Word to store |
| wrFlag | output | 1 | Full (active low) in standard mode; input-ready (1 = refuse) in fall-through mode |
| rdClk | input | 1 | Read-side clock |
| rdEn | input | 1 | Read request, active high |
| rdData | output | DATA_W | Output word register |
| rdFlag | output | 1 | Empty (active low) in standard mode; output-ready (active low) in fall-through mode |
| rstN | input | 1 | Reset, active low, synchronous in each domain |
| fwftSel | input | 1 | Mode select, sampled only during reset |

## Verification
A write reaches the read side two `rdClk` edges after its write edge. At that point the standard empty indication rises. The fall-through output and its ready flag follow one `rdClk` edge later. The bench counts read-clock edges from the exact write edge and requires exactly two and three edges for these results. The full indications depend only on the local pointer, so they are sampled at the first write-clock falling edge after the decisive write. A standard read shows its word at the falling edge after the read edge. Flags that depend on the opposite domain, such as the release from full, are sampled only after several edges of both clocks have passed.

// File: rtl/dual_mode_fifo_pkg.sv
package dual_mode_fifo_pkg;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] wrAddr;
    logic              rdStb;
    logic [ADDR_W-1:0] rdAddr;
  } fifo_strobe_t;
endpackage

// File: rtl/dual_mode_fifo_sync.sv
module dual_mode_fifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dual_mode_fifo_ctrl.sv
module dual_mode_fifo_ctrl
  import dual_mode_fifo_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W:0]   rdGraySync,
  input  logic [ADDR_W:0]   wrGraySync,
  output logic [ADDR_W:0]   wrGray,
  output logic [ADDR_W:0]   rdGray,
  output fifo_strobe_t      stb,
  output logic              wrFlag,
  output logic              rdFlag,
  output logic              modeW,
  output logic              modeR
);
  logic [ADDR_W:0] wrBin, wrBinNext, rdBin, rdBinNext;
  logic            memFull, memEmpty, wrDo, rdLoad, outValid;

  // write domain
  assign wrBinNext = wrBin + (ADDR_W+1)'(1);
  assign memFull   = (wrGray == {~rdGraySync[ADDR_W:ADDR_W-1], rdGraySync[ADDR_W-2:0]});
  assign wrDo      = wrEn && !memFull;
  assign wrFlag    = modeW ? memFull : ~memFull;

  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      modeW  <= fwftSel;
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrDo) begin
      wrBin  <= wrBinNext;
      wrGray <= (wrBinNext >> 1) ^ wrBinNext;
    end
  end

  // read domain
  assign rdBinNext = rdBin + (ADDR_W+1)'(1);
  assign memEmpty  = (rdGray == wrGraySync);

  always_comb begin
    if (modeR) rdLoad = !memEmpty && (!outValid || rdEn);
    else       rdLoad = rdEn && !memEmpty;
  end

  assign rdFlag = modeR ? ~outValid : ~memEmpty;

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      modeR    <= fwftSel;
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdLoad) begin
        rdBin  <= rdBinNext;
        rdGray <= (rdBinNext >> 1) ^ rdBinNext;
      end
      if (modeR) begin
        if (rdLoad)    outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.wrStb  = wrDo;
    stb.wrAddr = wrBin[ADDR_W-1:0];
    stb.rdStb  = rdLoad;
    stb.rdAddr = rdBin[ADDR_W-1:0];
  end
endmodule

// File: rtl/dual_mode_fifo_data.sv
module dual_mode_fifo_data
  import dual_mode_fifo_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifo_strobe_t      stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[stb.wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= mem[stb.rdAddr];
  end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dual_mode_fifo_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFlag,
  input  logic              rdClk,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFlag,
  input  logic              rstN,
  input  logic              fwftSel
);
  localparam int PTR_W = ADDR_W + 1;

  fifo_strobe_t     stb;
  logic [PTR_W-1:0] wrGray, rdGray, wrGraySync, rdGraySync;
  logic             modeW, modeR;

  dual_mode_fifo_sync #(.W(PTR_W)) u_wr2rd (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync));

  dual_mode_fifo_sync #(.W(PTR_W)) u_rd2wr (
    .clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync));

  dual_mode_fifo_ctrl u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .rdEn(rdEn), .rdGraySync(rdGraySync), .wrGraySync(wrGraySync),
    .wrGray(wrGray), .rdGray(rdGray), .stb(stb), .wrFlag(wrFlag),
    .rdFlag(rdFlag), .modeW(modeW), .modeR(modeR));

  dual_mode_fifo_data #(.DATA_W(DATA_W)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrData(wrData), .rdData(rdData));
endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int PTR_W  = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              wrFlag,
  input logic              rdFlag,
  input logic [DATA_W-1:0] rdData,
  input logic              modeW,
  input logic              modeR,
  input logic              wrStb,
  input logic [PTR_W-1:0]  wrGray,
  input logic [PTR_W-1:0]  rdGray
);
  p_mode_hold_r1: assert property (@(posedge rdClk) disable iff (!rstN)
    $stable(modeR));

  p_std_hold_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    (!modeR && !rdEn) |=> $stable(rdData));

  p_empty_read_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    (!modeR && !rdFlag) |=> $stable(rdData));

  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && (modeW ? wrFlag : !wrFlag)) |-> !wrStb);

  p_fwft_hold_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    (modeR && !rdFlag && !rdEn) |=> ($stable(rdData) && !rdFlag));

  p_wr_gray_r10: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  p_rd_gray_r10: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .wrFlag(wrFlag), .rdFlag(rdFlag), .rdData(rdData), .modeW(modeW),
  .modeR(modeR), .wrStb(stb.wrStb), .wrGray(wrGray), .rdGray(rdGray));

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
  localparam int DATA_W = 9;
  localparam int NVEC   = 8;
  localparam logic [DATA_W-1:0] VEC [NVEC] = '{
    9'h1FF, 9'h000, 9'h155, 9'h0AA, 9'h101, 9'h0FE, 9'h033, 9'h1C0};

  logic              wrClk = 1'b0, rdClk = 1'b0;
  logic              wrEn = 1'b0, rdEn = 1'b0, rstN = 1'b0, fwftSel = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              wrFlag, rdFlag;
  int                checks = 0, errors = 0, rdEdges = 0;

  dual_mode_fifo #(.DATA_W(DATA_W)) u_dut (
    .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData), .wrFlag(wrFlag),
    .rdClk(rdClk), .rdEn(rdEn), .rdData(rdData), .rdFlag(rdFlag),
    .rstN(rstN), .fwftSel(fwftSel));

  always #10 wrClk = ~wrClk;
  initial begin
    #3;
    forever #14 rdClk = ~rdClk;
  end
  always @(posedge rdClk) rdEdges++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (6) @(negedge wrClk);
  endtask

  task automatic doReset(input bit mode);
    rstN = 1'b0; fwftSel = mode; wrEn = 1'b0; rdEn = 1'b0;
    repeat (4) @(posedge rdClk);
    repeat (4) @(posedge wrClk);
    @(negedge wrClk) rstN = 1'b1;
    settle();
  endtask

  task automatic writeWord(input logic [DATA_W-1:0] d);
    @(negedge wrClk) begin wrEn = 1'b1; wrData = d; end
    @(negedge wrClk) wrEn = 1'b0;
  endtask

  task automatic stdRead(output logic [DATA_W-1:0] d);
    @(negedge rdClk) rdEn = 1'b1;
    @(negedge rdClk) rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic fwftRead(output logic [DATA_W-1:0] d, output logic flagSeen);
    @(negedge rdClk);
    d = rdData; flagSeen = rdFlag;
    rdEn = 1'b1;
    @(negedge rdClk) rdEn = 1'b0;
  endtask

  task automatic latency(input bit fwft, input logic [DATA_W-1:0] d, input int expEdges,
                         input string req);
    int base;
    @(negedge wrClk) begin wrEn = 1'b1; wrData = d; end
    @(posedge wrClk) base = rdEdges;
    @(negedge wrClk) wrEn = 1'b0;
    for (int n = 0; n < 12; n++) begin
      @(negedge rdClk);
      if (fwft ? (rdFlag == 1'b0) : (rdFlag == 1'b1)) break;
    end
    check(rdEdges - base == expEdges, req, rdEdges - base, expEdges);
    if (fwft) check(rdData == d, req, int'(rdData), int'(d));
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] got;
    logic              fl;

    // ---------------- standard mode ----------------
    doReset(1'b0);
    check(rdFlag == 1'b0, "R9 std empty", rdFlag, 0);
    check(wrFlag == 1'b1, "R9 std full", wrFlag, 1);
    check(rdData == '0, "R9 data", int'(rdData), 0);

    // R1: mode pin changes after reset are ignored
    fwftSel = 1'b1;
    // R3 latency of empty flag; R2 word not on output yet
    latency(1'b0, 9'h0C3, 2, "R3 empty latency");
    settle();
    check(rdFlag == 1'b1, "R1 std polarity kept", rdFlag, 1);
    check(rdData == '0, "R2 no fall-through", int'(rdData), 0);
    stdRead(got);
    check(got == 9'h0C3, "R2 read moves word", int'(got), 'h0C3);
    check(rdFlag == 1'b0, "R3 empty after last", rdFlag, 0);
    stdRead(got);
    check(got == 9'h0C3, "R3 read while empty ignored", int'(got), 'h0C3);

    // R5 table walk, standard mode
    foreach (VEC[i]) writeWord(VEC[i]);
    settle();
    foreach (VEC[i]) begin
      stdRead(got);
      check(got == VEC[i], "R5 std order", int'(got), int'(VEC[i]));
    end

    // R4 full in standard mode
    settle();
    for (int i = 0; i < 255; i++) writeWord(DATA_W'(i));
    check(wrFlag == 1'b1, "R4 not full at 255", wrFlag, 1);
    writeWord(9'd255);
    check(wrFlag == 1'b0, "R4 full at 256", wrFlag, 0);
    writeWord(9'h1AA);
    settle();
    stdRead(got);
    check(got == 9'd0, "R4 first after full", int'(got), 0);
    settle();
    check(wrFlag == 1'b1, "R4 full released", wrFlag, 1);
    for (int i = 1; i < 256; i++) begin
      stdRead(got);
      if (got != DATA_W'(i)) check(1'b0, "R4 drain", int'(got), i);
    end
    check(got == 9'd255, "R4 last word", int'(got), 255);
    check(rdFlag == 1'b0, "R4 overflow write dropped", rdFlag, 0);

    // ---------------- fall-through mode ----------------
    doReset(1'b1);
    check(rdFlag == 1'b1, "R9 fwft not ready", rdFlag, 1);
    check(wrFlag == 1'b0, "R9 fwft input ready", wrFlag, 0);
    check(rdData == '0, "R9 fwft data", int'(rdData), 0);
    fwftSel = 1'b0;
    latency(1'b1, 9'h13C, 3, "R6 fall-through latency");
    settle();
    check(rdFlag == 1'b0 && rdData == 9'h13C, "R7 held without read", int'(rdData), 'h13C);
    fwftRead(got, fl);
    check(got == 9'h13C && fl == 1'b0, "R7 consume", int'(got), 'h13C);
    check(rdFlag == 1'b1, "R7 not ready after last", rdFlag, 1);
    fwftRead(got, fl);
    check(rdData == 9'h13C && rdFlag == 1'b1, "R7 read while empty ignored", int'(rdData), 'h13C);

    // R5 table walk, fall-through mode
    foreach (VEC[i]) writeWord(VEC[i]);
    settle();
    foreach (VEC[i]) begin
      fwftRead(got, fl);
      check(got == VEC[i] && fl == 1'b0, "R5 fwft order", int'(got), int'(VEC[i]));
    end

    // R8 full in fall-through mode
    settle();
    writeWord(9'd0);
    settle();
    for (int i = 1; i < 256; i++) writeWord(DATA_W'(i));
    check(wrFlag == 1'b0, "R8 ready at 256", wrFlag, 0);
    writeWord(9'd256);
    check(wrFlag == 1'b1, "R8 not ready at 257", wrFlag, 1);
    writeWord(9'h1AA);
    settle();
    fwftRead(got, fl);
    check(got == 9'd0, "R8 first after full", int'(got), 0);
    settle();
    check(wrFlag == 1'b0, "R8 ready released", wrFlag, 0);
    for (int i = 1; i < 257; i++) begin
      fwftRead(got, fl);
      if (got != DATA_W'(i) || fl != 1'b0) check(1'b0, "R8 drain", int'(got), i);
    end
    check(got == 9'd256, "R8 last word", int'(got), 256);
    settle();
    check(rdFlag == 1'b1, "R8 overflow write dropped", rdFlag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule